// File: doc/BRIEF.md
# Configurable Output Macrocell Bank

This block is the output stage that sits between the product-term array of a small programmable logic device and its I/O pads. Each cell takes the OR-sum of its product terms. It either stores that sum in a D flip-flop or passes it straight through, and it can invert the result. The cell then presents the value, with its output enable, to the pad. A feedback bit goes back into the array. In registered mode the feedback is the flip-flop output. In combinatorial mode it is the value seen at the pin.

All cells share one clock, one global asynchronous reset and one global synchronous preset. Each cell has its own two configuration bits. The bypass bit (S1) chooses registered (0) or combinatorial (1). The polarity bit (S0) chooses active-low (0) or active-high (1). Taken together, {S1,S0} = 00 is registered active-low, 01 is registered active-high, 10 is combinatorial active-low and 11 is combinatorial active-high. A configuration bit held at ground selects the 0 path, and an erased bit selects the 1 path. The pad itself lies outside the block. It is represented by an output value, an enable and the sensed pin level.

Top module: `mcell_bank`

## Requirements
- R1: With reset and preset both low, every flip-flop loads its cell's sum on the rising clock edge. A registered active-high cell ({S1,S0}=01) then drives pin_out equal to the sum present at that edge.
- R2: A registered active-low cell ({S1,S0}=00) drives pin_out as the inverse of its flip-flop content.
- R3: A combinatorial cell drives pin_out from the current sum in the same cycle, with no clock edge in between. It drives the sum unchanged for {S1,S0}=11 and the inverted sum for {S1,S0}=10.
- R4: In registered mode (S1=0) the feedback equals the flip-flop content, without inversion, for either polarity.
- R5: In combinatorial mode (S1=1) the feedback equals the sensed pin level pin_in, including when the output is disabled and the pin is driven from outside.
- R6: Raising the global reset clears every flip-flop at once, without a clock edge. A registered active-low cell then drives pin_out high and a registered active-high cell drives it low. At power-up the reset leaves every flip-flop in this cleared state.
- R7: The global preset sets every flip-flop to 1 at a rising clock edge. Raising the preset between edges leaves the outputs unchanged until that edge.
- R8: When reset and preset are both high, the flip-flops stay cleared.
- R9: pin_oe of each cell follows that cell's output-enable input in every mode.
- R10: The flip-flop keeps loading the sum while its cell is in combinatorial mode. Switching the cell to registered active-high shows the sum from the last edge at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all cell flip-flops (rising edge) |
| areset_i | input | 1 | Global asynchronous reset, active high |
| spreset_i | input | 1 | Global synchronous preset, active high |
| sum_i | input | N_CELLS | OR-sum from the product-term array, one bit per cell |
| oe_i | input | N_CELLS | Per-cell output enable |
| cfg_bypass_i | input | N_CELLS | S1: 0 registered, 1 combinatorial |
| cfg_pol_i | input | N_CELLS | S0: 0 active-low, 1 active-high |
| pin_in_i | input | N_CELLS | Sensed pin level |
| pin_out_o | output | N_CELLS | Value driven toward the pad |
| pin_oe_o | output | N_CELLS | Pad driver enable |
| fb_o | output | N_CELLS | Feedback into the product-term array |

## Verification
The hardest situations to reach are the ones where the global controls overlap the normal data path. Examples are a reset that arrives partway through a cycle while a preset is pending, or a cell that changes mode right after its flip-flop loaded a value the pin was not showing. Random cycles pick the configuration, the sums and the sensed pin levels independently for every cell, and they sometimes raise preset, reset or both. Directed steps then place a preset between edges, reset and preset together, and a switch from combinatorial to registered mode, each at the exact point in the cycle that matters.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

   typedef enum logic [1:0] {
      MODE_REG_LOW   = 2'b00,
      MODE_REG_HIGH  = 2'b01,
      MODE_COMB_LOW  = 2'b10,
      MODE_COMB_HIGH = 2'b11
   } cell_mode_e;

   function automatic cell_mode_e make_mode(input logic bypass, input logic pol);
      return cell_mode_e'({bypass, pol});
   endfunction

   function automatic logic mode_level(input cell_mode_e m, input logic q, input logic sum);
      logic raw;
      raw = m[1] ? sum : q;
      return m[0] ? raw : ~raw;
   endfunction

endpackage

// File: rtl/mcell_store.sv
module mcell_store #(
   parameter int unsigned N_CELLS = 4
) (
   input  logic               clk,
   input  logic               areset,
   input  logic               spreset,
   input  logic [N_CELLS-1:0] d,
   output logic [N_CELLS-1:0] q
);

   localparam logic [N_CELLS-1:0] ALL_SET = {N_CELLS{1'b1}};

   always_ff @(posedge clk or posedge areset) begin
      if (areset)       q <= '0;
      else if (spreset) q <= ALL_SET;
      else              q <= d;
   end

   logic past_valid;
   always_ff @(posedge clk or posedge areset) begin
      if (areset) past_valid <= 1'b0;
      else        past_valid <= 1'b1;
   end

   assert_capture_R1: assert property (@(posedge clk) disable iff (areset)
      (past_valid && !$past(spreset)) |-> (q == $past(d)));

   assert_preset_sets_R7: assert property (@(posedge clk) disable iff (areset)
      (past_valid && $past(spreset)) |-> (q == ALL_SET));

endmodule

// File: rtl/mcell_route.sv
module mcell_route
   import mcell_pkg::*;
#(
   parameter int unsigned N_CELLS = 4
) (
   input  logic               clk,
   input  logic               areset,
   input  logic [N_CELLS-1:0] q,
   input  logic [N_CELLS-1:0] sum,
   input  logic [N_CELLS-1:0] pin_in,
   input  logic [N_CELLS-1:0] oe,
   input  logic [N_CELLS-1:0] bypass,
   input  logic [N_CELLS-1:0] pol,
   output logic [N_CELLS-1:0] pin_out,
   output logic [N_CELLS-1:0] pin_oe,
   output logic [N_CELLS-1:0] fb
);

   for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
      cell_mode_e mode;
      always_comb begin
         mode       = make_mode(bypass[i], pol[i]);
         pin_out[i] = mode_level(mode, q[i], sum[i]);
         pin_oe[i]  = oe[i];
         fb[i]      = mode[1] ? pin_in[i] : q[i];
      end

      assert_reg_polarity_R2: assert property (@(posedge clk) disable iff (areset)
         !bypass[i] |-> (pin_out[i] == (pol[i] ? fb[i] : ~fb[i])));
   end

endmodule

// File: rtl/mcell_bank.sv
module mcell_bank #(
   parameter int unsigned N_CELLS = 4
) (
   input  logic               clk,
   input  logic               areset_i,
   input  logic               spreset_i,
   input  logic [N_CELLS-1:0] sum_i,
   input  logic [N_CELLS-1:0] oe_i,
   input  logic [N_CELLS-1:0] cfg_bypass_i,
   input  logic [N_CELLS-1:0] cfg_pol_i,
   input  logic [N_CELLS-1:0] pin_in_i,
   output logic [N_CELLS-1:0] pin_out_o,
   output logic [N_CELLS-1:0] pin_oe_o,
   output logic [N_CELLS-1:0] fb_o
);

   if (N_CELLS < 1 || N_CELLS > 64) begin : g_bad_cells
      $error("mcell_bank: N_CELLS must be within 1..64");
   end

   logic [N_CELLS-1:0] q;

   mcell_store #(.N_CELLS(N_CELLS)) u_store (
      .clk     (clk),
      .areset  (areset_i),
      .spreset (spreset_i),
      .d       (sum_i),
      .q       (q)
   );

   mcell_route #(.N_CELLS(N_CELLS)) u_route (
      .clk     (clk),
      .areset  (areset_i),
      .q       (q),
      .sum     (sum_i),
      .pin_in  (pin_in_i),
      .oe      (oe_i),
      .bypass  (cfg_bypass_i),
      .pol     (cfg_pol_i),
      .pin_out (pin_out_o),
      .pin_oe  (pin_oe_o),
      .fb      (fb_o)
   );

   logic past_valid;
   always_ff @(posedge clk or posedge areset_i) begin
      if (areset_i) past_valid <= 1'b0;
      else          past_valid <= 1'b1;
   end

   for (genvar i = 0; i < N_CELLS; i++) begin : g_chk
      assert_reg_feedback_R4: assert property (@(posedge clk) disable iff (areset_i)
         (past_valid && !cfg_bypass_i[i] && !$past(spreset_i)) |-> (fb_o[i] == $past(sum_i[i])));
      assert_enable_pass_R9: assert property (@(posedge clk) disable iff (areset_i)
         pin_oe_o[i] == oe_i[i]);
   end

endmodule

// File: tb/mcell_bank_tb.sv
module mcell_bank_tb;

   localparam int N = 4;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         areset, spreset;
   logic [N-1:0] sum, oe, byp, pol, pin_in;
   logic [N-1:0] pin_out, pin_oe, fb;
   logic [N-1:0] m_q;
   int           errors = 0;
   int           checks = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mcell_bank #(.N_CELLS(N)) u_dut (
      .clk(clk), .areset_i(areset), .spreset_i(spreset), .sum_i(sum), .oe_i(oe),
      .cfg_bypass_i(byp), .cfg_pol_i(pol), .pin_in_i(pin_in),
      .pin_out_o(pin_out), .pin_oe_o(pin_oe), .fb_o(fb)
   );

   // Bench model of the flip-flops, written from R1, R6, R7 and R8.
   always @(posedge clk or posedge areset) begin
      if (areset)       m_q <= '0;
      else if (spreset) m_q <= '1;
      else              m_q <= sum;
   end

   function automatic logic exp_pin(logic q, logic s, logic b, logic p);
      logic v;
      v = b ? s : q;
      return p ? v : ~v;
   endfunction

   function automatic logic exp_fb(logic q, logic pi, logic b);
      return b ? pi : q;
   endfunction

   task automatic chk(string req, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic check_all();
      for (int i = 0; i < N; i++) begin
         chk(byp[i] ? "R3 comb pin" : (pol[i] ? "R1 reg pin" : "R2 reg pin"),
             pin_out[i], exp_pin(m_q[i], sum[i], byp[i], pol[i]));
         chk(byp[i] ? "R5 comb fb" : "R4 reg fb", fb[i], exp_fb(m_q[i], pin_in[i], byp[i]));
         chk("R9 oe", pin_oe[i], oe[i]);
      end
   endtask

   initial begin
      int seed_dummy;
      seed_dummy = $urandom(32'h5eed_1234);
      areset = 1'b1; spreset = 1'b0; sum = '0; oe = '0; byp = '0; pol = 4'b0101; pin_in = '0;
      #2;
      // R6: power-up reset state
      for (int i = 0; i < N; i++) chk("R6 reset pin", pin_out[i], ~pol[i]);
      @(negedge clk); @(negedge clk);
      areset = 1'b0;

      // R1: capture with registered active-high
      pol = '1; sum = 4'b1011;
      @(posedge clk); #1;
      chk("R1 capture", pin_out[0], 1'b1);
      chk("R1 capture", pin_out[2], 1'b0);
      chk("R4 fb", fb[3], 1'b1);

      // R7: preset mid-cycle has no effect until the edge
      @(negedge clk); sum = 4'b0000; spreset = 1'b1; #1;
      chk("R7 preset waits", pin_out[2], 1'b0);
      @(posedge clk); #1;
      for (int i = 0; i < N; i++) chk("R7 preset set", pin_out[i], 1'b1);

      // R6: async reset between edges
      @(negedge clk); spreset = 1'b0; pol = 4'b0011; areset = 1'b1; #1;
      chk("R6 async low pin", pin_out[3], 1'b1);
      chk("R6 async high pin", pin_out[0], 1'b0);
      @(negedge clk); areset = 1'b0;

      // R8: reset and preset together
      @(negedge clk); sum = '1; @(posedge clk); #1;
      chk("R8 pre", pin_out[0], 1'b1);
      @(negedge clk); areset = 1'b1; spreset = 1'b1;
      @(posedge clk); #1;
      chk("R8 reset wins", pin_out[0], 1'b0);
      chk("R8 reset wins", fb[1], 1'b0);
      @(negedge clk); areset = 1'b0; spreset = 1'b0;

      // R5: combinatorial, disabled pin driven externally
      byp = '1; pol = '1; oe = '0; sum = 4'b0001; pin_in = 4'b1010; #1;
      chk("R5 ext pin fb", fb[1], 1'b1);
      chk("R5 ext pin fb", fb[0], 1'b0);
      chk("R3 comb now", pin_out[0], 1'b1);
      chk("R9 oe low", pin_oe[0], 1'b0);

      // R10: flop loads in comb mode, visible after switch
      @(posedge clk); #1;
      @(negedge clk); sum = 4'b0000; byp = '0; #1;
      chk("R10 switch", pin_out[0], 1'b1);
      chk("R10 switch", pin_out[1], 1'b0);

      // Random phase
      for (int c = 0; c < 400; c++) begin
         @(negedge clk);
         areset  = (($urandom % 32) == 0);
         spreset = (($urandom % 8) == 0);
         sum = N'($urandom); oe = N'($urandom); byp = N'($urandom);
         pol = N'($urandom); pin_in = N'($urandom);
         #4;
         check_all();
      end
      areset = 1'b0;

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule